// File: doc/BRIEF.md
# Masked Condition-Field Logic Unit

This unit holds a 32-bit condition register split into eight 4-bit fields. It executes two per-bit lookup operations. Each operation rewrites one destination field as a whole. Each bit of the destination is produced by a small truth table:

- **Ternary-immediate form.** The table index is a 3-bit value. It is built from the destination's old bit and the matching bits of two source fields. The 8-entry table is carried inside the instruction word.
- **Dynamic binary form.** The table index is a 2-bit value. It is built from the destination's old bit and the matching bit of one source field. The 4-entry table is the current contents of another condition field, so software can choose the logic function at run time.

A 4-bit write mask picks which destination bits take the lookup result. The other destination bits keep their old values. An instruction whose mask is all zeros changes nothing and raises a trap flag. The trap flag is high in the same cycle as the valid strobe.

The unit sits in the execute stage of a core. It receives a 32-bit instruction word, a valid strobe and a one-bit operation select, which is already decoded. Opcode checking is not part of this unit. The register contents are driven out continuously.

Top module: `cfl_unit`

## Requirements
- R1: While the reset input is low, and after it is released, the condition register reads zero and the trap flag is low until the first instruction.
- R2: Field n (n = 0..7) occupies register bits [31-4n : 28-4n], so field 0 is the most significant nibble. Field bit 0 is the most significant bit of its nibble.
- R3: The fields are decoded as follows:
  - destination field number = insn[25:23];
  - first source field number = insn[20:18];
  - second source field number = insn[15:13];
  - mask = {insn[22], insn[21], insn[17], insn[16]}, where mask[3] governs the most significant bit of the nibble.
- R4: With op_sel = 0 (ternary form), the table entry for index j is insn[12-j] for j = 0..6 and insn[0] for j = 7. The index for each bit is {old destination bit, first source bit, second source bit}.
- R5: With op_sel = 1 (binary form), the index for each bit is {old destination bit, first source bit}. Entry j of the table is bit j of the field named by the second source number, where bit 0 is that field's most significant bit.
- R6: A destination bit is replaced only where its mask bit is 1. Otherwise it keeps its old value.
- R7: A valid instruction with an all-zero mask raises trap in the same cycle and leaves the whole register unchanged. A nonzero mask never raises trap.
- R8: Fields other than the destination never change.
- R9: All source and table fields are read from the value before the update. This holds even when a source is also the destination.
- R10: With insn_valid low, the register holds its value and trap stays low, whatever is on insn and op_sel.
- R11: The update appears at the clock edge that samples insn_valid high. Before that edge the register still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| insn_valid | input | 1 | Instruction strobe, one cycle per instruction |
| op_sel | input | 1 | 0 selects the ternary-immediate form, 1 the dynamic binary form |
| insn | input | 32 | Instruction word |
| cr_q | output | 32 | Condition register contents |
| trap | output | 1 | Illegal-instruction pulse for an all-zero mask |

## Verification
The bound checker watches several properties on every cycle:
- bits outside the masked part of the destination field keep their values across each instruction;
- the register does not move on idle or trapping cycles;
- trap is high exactly when a valid instruction carries a zero mask.

The checker cannot tell whether a rewritten bit took the right table entry. That needs the bench's reference model, which is driven through the following scenarios:
- field loading;
- several ternary tables;
- tables taken from other fields;
- aliased source and destination fields;
- random instruction streams.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int CR_W       = 32;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = CR_W / FIELD_W;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int TERN_W     = 8;
  localparam int BIN_W      = 4;
  localparam int INSN_W     = 32;

  typedef enum logic {
    OP_TERN = 1'b0,
    OP_BIN  = 1'b1
  } cfl_op_e;

  typedef struct packed {
    logic [IDX_W-1:0]   dst;
    logic [IDX_W-1:0]   srca;
    logic [IDX_W-1:0]   srcb;
    logic [FIELD_W-1:0] mask;
    logic [TERN_W-1:0]  tbl;   // tbl[7] is entry 0
  } cfl_dec_t;
endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfl_decode.sv
module cfl_decode
  import cfl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              insn_valid,
  output cfl_dec_t          dec,
  output logic              trap
);
  always_comb begin
    dec.dst  = insn[25:23];
    dec.srca = insn[20:18];
    dec.srcb = insn[15:13];
    dec.mask = {insn[22:21], insn[17:16]};
    dec.tbl  = {insn[12:6], insn[0]};
    trap     = insn_valid && (dec.mask == '0);
  end
endmodule

// File: rtl/cfl_field_mux.sv
module cfl_field_mux #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  localparam int CR_W      = FIELD_W * NUM_FIELDS,
  localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
  input  logic [CR_W-1:0]    cr,
  input  logic [IDX_W-1:0]   sel,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] fields [NUM_FIELDS];

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_split
    assign fields[n] = cr[CR_W-1-n*FIELD_W -: FIELD_W];
  end

  assign field = fields[sel];
endmodule

// File: rtl/cfl_lane.sv
module cfl_lane
  import cfl_pkg::*;
(
  input  cfl_op_e           op,
  input  logic              d_bit,
  input  logic              a_bit,
  input  logic              b_bit,
  input  logic [TERN_W-1:0] tbl,
  input  logic [BIN_W-1:0]  lut,
  input  logic              wr_mask,
  output logic              new_bit
);
  logic [2:0] tern_idx;
  logic [1:0] bin_idx;
  logic       look;

  always_comb begin
    tern_idx = {d_bit, a_bit, b_bit};
    bin_idx  = {d_bit, a_bit};
    // entry 0 sits in the top bit of each table
    if (op == OP_TERN) begin
      look = tbl[~tern_idx];
    end else begin
      look = lut[~bin_idx];
    end
    new_bit = wr_mask ? look : d_bit;
  end
endmodule

// File: rtl/cfl_crfile.sv
module cfl_crfile #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  localparam int CR_W      = FIELD_W * NUM_FIELDS,
  localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FIELD_W-1:0] wr_field,
  output logic [CR_W-1:0]    cr_q
);
  logic [CR_W-1:0] cr_d;

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_field
    always_comb begin
      if (wr_en && (wr_idx == IDX_W'(n))) begin
        cr_d[CR_W-1-n*FIELD_W -: FIELD_W] = wr_field;
      end else begin
        cr_d[CR_W-1-n*FIELD_W -: FIELD_W] = cr_q[CR_W-1-n*FIELD_W -: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
    end else if (wr_en) begin
      cr_q <= cr_d;
    end
  end
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
  import cfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic              op_sel,
  input  logic [INSN_W-1:0] insn,
  output logic [CR_W-1:0]   cr_q,
  output logic              trap
);
  logic               rst_core_n;
  cfl_dec_t           dec;
  cfl_op_e            op;
  logic [FIELD_W-1:0] dst_f;
  logic [FIELD_W-1:0] srca_f;
  logic [FIELD_W-1:0] srcb_f;
  logic [FIELD_W-1:0] res_f;
  logic               wr_en;

  assign op = cfl_op_e'(op_sel);

  cfl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cfl_decode u_dec (
    .insn       (insn),
    .insn_valid (insn_valid),
    .dec        (dec),
    .trap       (trap)
  );

  // all reads come from the pre-update register value
  cfl_field_mux #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_mux_dst (
    .cr (cr_q), .sel (dec.dst), .field (dst_f)
  );
  cfl_field_mux #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_mux_a (
    .cr (cr_q), .sel (dec.srca), .field (srca_f)
  );
  cfl_field_mux #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_mux_b (
    .cr (cr_q), .sel (dec.srcb), .field (srcb_f)
  );

  for (genvar k = 0; k < FIELD_W; k++) begin : g_lane
    cfl_lane u_lane (
      .op      (op),
      .d_bit   (dst_f[k]),
      .a_bit   (srca_f[k]),
      .b_bit   (srcb_f[k]),
      .tbl     (dec.tbl),
      .lut     (srcb_f),
      .wr_mask (dec.mask[k]),
      .new_bit (res_f[k])
    );
  end

  assign wr_en = insn_valid && !trap;

  cfl_crfile #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_cr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_idx   (dec.dst),
    .wr_field (res_f),
    .cr_q     (cr_q)
  );
endmodule

// File: rtl/cfl_unit_chk.sv
module cfl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic [31:0] cr_q,
  input logic        trap
);
  logic [3:0]  mask_w;
  logic [2:0]  dst_w;
  logic [31:0] keep_w;

  always_comb begin
    mask_w = {insn[22:21], insn[17:16]};
    dst_w  = insn[25:23];
    keep_w = ~({28'd0, mask_w} << (5'd28 - {dst_w, 2'b00}));
  end

  // R6 R8
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> ((cr_q & $past(keep_w)) == ($past(cr_q) & $past(keep_w))));

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> $stable(cr_q));

  // R7
  trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mask_w == 4'd0) |-> trap);

  // R7
  trap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w != 4'd0) |-> !trap);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(cr_q));

  // R10
  idle_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> !trap);
endmodule

bind cfl_unit cfl_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .cr_q       (cr_q),
  .trap       (trap)
);

// File: tb/cfl_unit_bench.sv
`timescale 1ns/1ps
module cfl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic        op_sel;
  logic [31:0] insn;
  logic [31:0] cr_q;
  logic        trap;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model_cr;

  typedef struct {
    logic [31:0] cr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  cfl_unit u_cfl_unit (
    .clk (clk), .rst_n (rst_n), .insn_valid (insn_valid),
    .op_sel (op_sel), .insn (insn), .cr_q (cr_q), .trap (trap)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // msk[3] = field bit 0 (nibble MSB); tli[7] = table entry 0
  function automatic logic [31:0] enc(input int dst, input int sa, input int sb,
                                      input logic [3:0] msk, input logic [7:0] tli);
    logic [31:0] w;
    w        = 32'h0000_0014;
    w[25:23] = dst[2:0];
    w[22:21] = msk[3:2];
    w[17:16] = msk[1:0];
    w[20:18] = sa[2:0];
    w[15:13] = sb[2:0];
    w[12:6]  = tli[7:1];
    w[0]     = tli[0];
    return w;
  endfunction

  // reference model in big-endian bit numbering
  function automatic logic [31:0] model(input logic [31:0] cr, input logic [31:0] w,
                                        input logic op, output logic tr);
    int dst, sa, sb, j, mpos;
    logic d, a, b, v;
    logic [31:0] res;
    int mpos_tab [4] = '{9, 10, 14, 15};
    dst = int'(w[25:23]); sa = int'(w[20:18]); sb = int'(w[15:13]);
    tr  = 1'b1;
    for (int p = 0; p < 4; p++) if (w[31-mpos_tab[p]]) tr = 1'b0;
    res = cr;
    if (!tr) begin
      for (int p = 0; p < 4; p++) begin
        mpos = mpos_tab[p];
        if (w[31-mpos]) begin
          d = cr[31-(4*dst+p)]; a = cr[31-(4*sa+p)]; b = cr[31-(4*sb+p)];
          if (!op) begin
            j = 4*int'(d) + 2*int'(a) + int'(b);
            v = (j < 7) ? w[31-(19+j)] : w[0];
          end else begin
            j = 2*int'(d) + int'(a);
            v = cr[31-(4*sb+j)];
          end
          res[31-(4*dst+p)] = v;
        end
      end
    end
    return res;
  endfunction

  task automatic issue(input logic op, input logic [31:0] w, input string tag);
    logic tr;
    logic [31:0] nxt;
    @(negedge clk);
    op_sel = op; insn = w; insn_valid = 1'b1;
    nxt = model(model_cr, w, op, tr);
    #2;
    chk(trap === tr, tr ? "R7 trap" : {tag, " trap"}, {31'd0, trap}, {31'd0, tr});
    chk(cr_q === model_cr, "R11 pre-edge", cr_q, model_cr);
    model_cr = nxt;
    exp_q.push_back('{cr: nxt, tag: tag});
  endtask

  task automatic idle(input logic [31:0] junk);
    @(negedge clk);
    insn_valid = 1'b0; insn = junk; op_sel = junk[3];
    #2;
    chk(trap === 1'b0, "R10 trap", {31'd0, trap}, 32'd0);
    exp_q.push_back('{cr: model_cr, tag: "R10"});
  endtask

  task automatic set_field(input int f, input logic [3:0] v, input string tag);
    if (v != 4'h0) issue(1'b0, enc(f, 0, 0, v, 8'hFF), tag);
    if (v != 4'hF) issue(1'b0, enc(f, 0, 0, ~v, 8'h00), tag);
  endtask

  // monitor: compare the register after each edge against the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cr_q === e.cr, e.tag, cr_q, e.cr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0; op_sel = 1'b0; insn = 32'hFFFF_FFFF;
    model_cr = 32'd0;
    repeat (3) @(negedge clk);
    #2;
    chk(cr_q === 32'd0, "R1 in reset", cr_q, 32'd0);
    @(negedge clk);
    rst_n = 1'b1; insn = 32'd0;
    repeat (4) @(negedge clk);
    #2;
    chk(cr_q === 32'd0, "R1 after release", cr_q, 32'd0);
    chk(trap === 1'b0, "R1 trap", {31'd0, trap}, 32'd0);

    // R2: field 0 is the top nibble, field 7 the bottom
    set_field(0, 4'hA, "R2");
    set_field(7, 4'h5, "R2");
    set_field(3, 4'hC, "R2");
    set_field(5, 4'h6, "R2");
    repeat (2) @(negedge clk);
    chk(cr_q === 32'hA00C_0605, "R2 layout", cr_q, 32'hA00C_0605);

    // R4: ternary tables
    issue(1'b0, enc(1, 0, 7, 4'hF, 8'h96), "R4");
    issue(1'b0, enc(2, 3, 5, 4'hF, 8'hE8), "R4");
    issue(1'b0, enc(6, 0, 3, 4'hF, 8'h01), "R4");
    // R5: table from another field
    issue(1'b1, enc(4, 0, 3, 4'hF, 8'h00), "R5");
    issue(1'b1, enc(7, 5, 0, 4'hF, 8'h5A), "R5");
    // R6: partial masks
    issue(1'b0, enc(0, 7, 7, 4'b0101, 8'h00), "R6");
    issue(1'b1, enc(3, 5, 7, 4'b1000, 8'hFF), "R6");
    // R7: zero mask, both forms
    issue(1'b0, enc(0, 1, 2, 4'b0000, 8'hFF), "R7");
    issue(1'b1, enc(3, 3, 3, 4'b0000, 8'h00), "R7");
    // R9: aliasing
    issue(1'b0, enc(5, 5, 5, 4'hF, 8'h3C), "R9");
    issue(1'b1, enc(7, 7, 7, 4'hF, 8'h00), "R9");
    // R10: idle cycles with junk on the inputs
    idle(32'h0000_0000);
    idle(32'hFFFF_FFFF);
    idle(32'h1234_5678);

    // R3 R8: random stream
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      issue(r[31], r, (i % 2 == 0) ? "R3" : "R8");
      if (i % 17 == 0) idle($urandom);
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule